// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the status register of a serial NOR flash and decides whether each instruction from the host may run. An SPI shift front end delivers one finished instruction per chip-select rise. Each instruction arrives as an opcode, a 24-bit address, a data byte and a flag. The flag says whether the number of serial clocks was a whole number of bytes. The block applies the write-enable latch, the clock-count rule, block protection, hardware protection through the write-protect pin and deep power-down. It then pulses either an accept or a reject strobe.

Block protection always covers a region that starts at address 0. Its size is chosen by a 3-bit code in the status register. An accepted Program, Erase or Write Status starts a busy interval of a fixed number of clock cycles. The write-enable latch clears in the cycle the busy interval ends. The status byte is always visible on an output port, so a status read needs no special handling.

Top module: `spi_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, deep power-down is off, and neither strobe is high.
- R2: Write Enable (06h) sets the latch at status bit 1; Write Disable (04h) clears it.
- R3: Write Status (01h), Page Program (02h), Sector Erase (D8h) and Bulk Erase (C7h) are rejected without effect when the latch is clear; accept and reject never pulse together.
- R4: Those four instructions are rejected, with the latch left set, when the clock-count flag is low.
- R5: `addr_prot` is high when the address taken modulo 2 MiB lies below the protected size. The protected size is set by the 3-bit code at status bits 4:2. Code 0 protects nothing. Code 1 protects 4 KiB, 2 protects 8 KiB, 3 protects 16 KiB, 4 protects 32 KiB and 5 protects 64 KiB. Code 6 protects 1024 KiB and code 7 protects all 2048 KiB.
- R6: Page Program and Sector Erase to a protected address are rejected; to an unprotected address they are accepted.
- R7: Bulk Erase is accepted only when the protect code is 0.
- R8: An acceptance sets status bit 0 for exactly BUSY_CYCLES cycles, counted from the accepting edge. The latch clears in the same cycle that bit 0 clears.
- R9: While status bit 0 is set, every instruction is ignored: no strobe, no state change.
- R10: Status reads as {protect-lock, 0, 0, code[2:0], latch, busy}. An accepted Write Status loads protect-lock from data bit 7 and the code from data bits 4:2. All other data bits are ignored.
- R11: When protect-lock is set and `wp_n` is low, Write Status is rejected and leaves protect-lock and the code unchanged.
- R12: Deep Power-down (B9h) sets `dpd_active`. While it is set, only Release (ABh) has an effect, and Release clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_end | input | 1 | One-cycle pulse: an instruction completed at chip-select rise |
| cmd_op | input | 8 | Opcode of the instruction |
| cmd_addr | input | ADDR_W | Target address |
| cmd_data | input | 8 | Data byte for Write Status |
| cmd_bits_ok | input | 1 | Clock count was a multiple of eight |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status byte |
| cmd_accept | output | 1 | Modifying instruction accepted (one cycle) |
| cmd_reject | output | 1 | Modifying instruction rejected (one cycle) |
| addr_prot | output | 1 | `cmd_addr` lies in the protected region |
| dpd_active | output | 1 | Deep power-down in effect |

## Verification
The assertions check several rules on every cycle. No instruction is accepted while the latch is clear, or while busy, or when Write Status meets hardware protection. The two strobes never pulse together. An acceptance always raises busy, and busy falls together with the latch. Deep power-down holds the status byte steady against every opcode except Release. Only the bench scenarios can show the protected-size arithmetic over all eight codes and the address aliasing above 2 MiB. The same holds for the exact busy length, the ignored data bits of Write Status and the recovery from deep power-down.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RDP  = 8'hAB;

  typedef struct packed {
    logic       lock;
    logic [2:0] code;
  } nv_bits_t;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
  parameter int ADDR_W  = 24,
  parameter int MEM_AW  = 21,
  parameter int SECT_AW = 12
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int LW = MEM_AW + 1;

  logic [LW-1:0] limit;
  logic [LW-1:0] mem_a;
  logic          unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:MEM_AW];
  assign mem_a     = {1'b0, addr[MEM_AW-1:0]};

  always_comb begin
    case (code)
      3'd0:    limit = '0;
      3'd6:    limit = LW'(1) << (MEM_AW - 1);
      3'd7:    limit = LW'(1) << MEM_AW;
      default: limit = LW'(1) << (SECT_AW - 1 + int'(code));
    endcase
  end

  assign prot = (mem_a < limit);
endmodule

// File: rtl/wp_busy_timer.sv
module wp_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl #(
  parameter int ADDR_W      = 24,
  parameter int MEM_AW      = 21,
  parameter int SECT_AW     = 12,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_end,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              cmd_bits_ok,
  input  logic              wp_n,
  output logic [7:0]        status,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              addr_prot,
  output logic              dpd_active
);
  import spi_wp_pkg::*;

  logic     rst_i_n;
  nv_bits_t nv_q, nv_d;
  logic     wel_q, wel_d;
  logic     dpd_q, dpd_d;
  logic     acc_q, acc_d;
  logic     rej_q, rej_d;
  logic     busy, busy_done, start;
  logic     hw_locked, ok;
  logic     unused_data;

  assign unused_data = ^{cmd_data[6:5], cmd_data[1:0]};

  wp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  wp_region_decode #(
    .ADDR_W  (ADDR_W),
    .MEM_AW  (MEM_AW),
    .SECT_AW (SECT_AW)
  ) u_region (
    .code (nv_q.code),
    .addr (cmd_addr),
    .prot (addr_prot)
  );

  wp_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (start),
    .busy  (busy),
    .done  (busy_done)
  );

  assign hw_locked = nv_q.lock && !wp_n;

  always_comb begin
    nv_d  = nv_q;
    wel_d = wel_q;
    dpd_d = dpd_q;
    acc_d = 1'b0;
    rej_d = 1'b0;
    start = 1'b0;
    ok    = 1'b0;
    if (busy_done) wel_d = 1'b0;
    if (cmd_end) begin
      if (dpd_q) begin
        if (cmd_op == OP_RDP) dpd_d = 1'b0;
      end else if (!busy) begin
        case (cmd_op)
          OP_WREN: wel_d = 1'b1;
          OP_WRDI: wel_d = 1'b0;
          OP_DP:   dpd_d = 1'b1;
          OP_WRSR, OP_PP, OP_SE, OP_BE: begin
            ok = cmd_bits_ok && wel_q;
            if (cmd_op == OP_WRSR)      ok = ok && !hw_locked;
            else if (cmd_op == OP_BE)   ok = ok && (nv_q.code == 3'd0);
            else                        ok = ok && !addr_prot;
            if (ok) begin
              start = 1'b1;
              acc_d = 1'b1;
              if (cmd_op == OP_WRSR) begin
                nv_d.lock = cmd_data[7];
                nv_d.code = cmd_data[4:2];
              end
            end else begin
              rej_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      nv_q  <= '0;
      wel_q <= 1'b0;
      dpd_q <= 1'b0;
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      nv_q  <= nv_d;
      wel_q <= wel_d;
      dpd_q <= dpd_d;
      acc_q <= acc_d;
      rej_q <= rej_d;
    end
  end

  assign status     = {nv_q.lock, 2'b00, nv_q.code, wel_q, busy};
  assign cmd_accept = acc_q;
  assign cmd_reject = rej_q;
  assign dpd_active = dpd_q;
endmodule

// File: rtl/spi_wp_ctrl_chk.sv
module spi_wp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_end,
  input logic [7:0] cmd_op,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       dpd_active
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));

  assert_need_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && !status[1]) |=> !cmd_accept);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> status[0]);

  assert_wel_with_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && status[0]) |=> (!cmd_accept && !cmd_reject));

  assert_hw_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && cmd_op == 8'h01 && status[7] && !wp_n) |=> !cmd_accept);

  assert_dpd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_end && dpd_active && cmd_op != 8'hAB) |=> (dpd_active && $stable(status)));
endmodule

bind spi_wp_ctrl spi_wp_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_end    (cmd_end),
  .cmd_op     (cmd_op),
  .wp_n       (wp_n),
  .status     (status),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject),
  .dpd_active (dpd_active)
);

// File: tb/spi_wp_ctrl_tb.sv
module spi_wp_ctrl_tb_top;
  localparam int BC = 4;

  logic        clk;
  logic        rst_n;
  logic        cmd_end;
  logic [7:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        cmd_bits_ok;
  logic        wp_n;
  logic [7:0]  status;
  logic        cmd_accept, cmd_reject, addr_prot, dpd_active;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  spi_wp_ctrl #(.BUSY_CYCLES(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_bits_ok(cmd_bits_ok),
    .wp_n(wp_n), .status(status), .cmd_accept(cmd_accept),
    .cmd_reject(cmd_reject), .addr_prot(addr_prot), .dpd_active(dpd_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [23:0] a,
                       input logic [7:0] d, input logic ok);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_bits_ok = ok; cmd_end = 1'b1;
    @(negedge clk);
    cmd_end = 1'b0;
  endtask

  task automatic idle();
    repeat (BC + 1) @(negedge clk);
  endtask

  task automatic write_sr(input logic [7:0] d);
    wp_n = 1'b1;
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    issue(8'h01, 24'h0, d, 1'b1);
    chk("R10 write accepted", cmd_accept, 1);
    idle();
  endtask

  function automatic int exp_limit(input int code);
    int kb;
    if (code == 0)      kb = 0;
    else if (code == 7) kb = 2048;
    else if (code == 6) kb = 1024;
    else                kb = 4 << (code - 1);
    return kb * 1024;
  endfunction

  logic [23:0] alist [16];

  initial begin
    alist = '{24'h000000, 24'h000FFF, 24'h001000, 24'h001FFF,
              24'h002000, 24'h003FFF, 24'h004000, 24'h007FFF,
              24'h008000, 24'h00FFFF, 24'h010000, 24'h0FFFFF,
              24'h100000, 24'h1FFFFF, 24'hE00000, 24'hF01000};
    rst_n = 1'b0; cmd_end = 1'b0; cmd_op = 8'h0; cmd_addr = '0;
    cmd_data = 8'h0; cmd_bits_ok = 1'b1; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 status", status, 8'h00);
    chk("R1 dpd", dpd_active, 0);
    chk("R1 strobes", {cmd_accept, cmd_reject}, 0);

    // R2 latch set / clear
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    chk("R2 wren", status, 8'h02);
    issue(8'h04, 24'h0, 8'h0, 1'b1);
    chk("R2 wrdi", status, 8'h00);

    // R3 no latch -> reject
    foreach (alist[i]) begin
      if (i < 4) begin
        logic [7:0] op;
        op = (i == 0) ? 8'h01 : (i == 1) ? 8'h02 : (i == 2) ? 8'hD8 : 8'hC7;
        issue(op, 24'h1F0000, 8'h9C, 1'b1);
        chk("R3 reject w/o latch", {cmd_accept, cmd_reject}, 1);
        chk("R3 no busy", status, 8'h00);
      end
    end

    // R4 clock-count rule
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    issue(8'h02, 24'h1F0000, 8'h0, 1'b0);
    chk("R4 misaligned reject", {cmd_accept, cmd_reject}, 1);
    chk("R4 latch kept", status, 8'h02);
    issue(8'h02, 24'h1F0000, 8'h0, 1'b1);
    chk("R4 aligned accept", {cmd_accept, cmd_reject}, 2);

    // R8 busy length, latch clears with busy
    chk("R8 busy start", status, 8'h03);
    for (int k = 1; k <= BC; k++) begin
      @(negedge clk);
      chk("R8 busy window", status, (k < BC) ? 8'h03 : 8'h00);
    end

    // R9 commands ignored while busy
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    issue(8'hD8, 24'h1F0000, 8'h0, 1'b1);
    issue(8'h04, 24'h0, 8'h0, 1'b1);
    chk("R9 wrdi ignored", status, 8'h03);
    chk("R9 no strobe", {cmd_accept, cmd_reject}, 0);
    issue(8'hB9, 24'h0, 8'h0, 1'b1);
    chk("R9 dp ignored", dpd_active, 0);
    chk("R9 no strobe 2", {cmd_accept, cmd_reject}, 0);
    idle();
    chk("R9 end state", status, 8'h00);

    // R5 R6 R7 sweep over all codes
    for (int c = 0; c < 8; c++) begin
      write_sr(8'(c << 2));
      chk("R10 code load", status, c << 2);
      for (int i = 0; i < 16; i++) begin
        int lim;
        int exp_p;
        lim = exp_limit(c);
        exp_p = (int'(alist[i] % 24'h200000) < lim) ? 1 : 0;
        @(negedge clk);
        cmd_addr = alist[i];
        #1;
        chk("R5 addr_prot", addr_prot, exp_p);
        for (int s = 0; s < 2; s++) begin
          issue(8'h06, 24'h0, 8'h0, 1'b1);
          issue(s == 0 ? 8'h02 : 8'hD8, alist[i], 8'h0, 1'b1);
          chk("R6 program/erase gate", {cmd_accept, cmd_reject}, exp_p ? 1 : 2);
          if (!exp_p) idle();
          else issue(8'h04, 24'h0, 8'h0, 1'b1);
        end
      end
      issue(8'h06, 24'h0, 8'h0, 1'b1);
      issue(8'hC7, 24'h0, 8'h0, 1'b1);
      chk("R7 bulk gate", {cmd_accept, cmd_reject}, (c == 0) ? 2 : 1);
      if (c == 0) idle();
      else issue(8'h04, 24'h0, 8'h0, 1'b1);
    end

    // R10 format and ignored data bits
    wp_n = 1'b1;
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    issue(8'h01, 24'h0, 8'hFF, 1'b1);
    chk("R10 during busy", status, 8'h9F);
    idle();
    chk("R10 after busy", status, 8'h9C);
    write_sr(8'h63);
    chk("R10 ignored bits", status, 8'h00);

    // R11 hardware lock
    write_sr(8'h88);
    chk("R11 set lock", status, 8'h88);
    wp_n = 1'b0;
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    issue(8'h01, 24'h0, 8'h00, 1'b1);
    chk("R11 locked reject", {cmd_accept, cmd_reject}, 1);
    chk("R11 bits kept", status, 8'h8A);
    wp_n = 1'b1;
    issue(8'h01, 24'h0, 8'h00, 1'b1);
    chk("R11 unlocked accept", {cmd_accept, cmd_reject}, 2);
    idle();
    chk("R11 cleared", status, 8'h00);
    wp_n = 1'b0;
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    issue(8'h01, 24'h0, 8'h04, 1'b1);
    chk("R11 pin low, lock clear", {cmd_accept, cmd_reject}, 2);
    idle();
    chk("R11 code written", status, 8'h04);
    write_sr(8'h00);

    // R12 deep power-down
    issue(8'h06, 24'h0, 8'h0, 1'b1);
    issue(8'hB9, 24'h0, 8'h0, 1'b1);
    chk("R12 enter", dpd_active, 1);
    for (int j = 0; j < 7; j++) begin
      logic [7:0] op;
      case (j)
        0: op = 8'h04; 1: op = 8'h06; 2: op = 8'h02; 3: op = 8'h01;
        4: op = 8'hC7; 5: op = 8'hD8; default: op = 8'h05;
      endcase
      issue(op, 24'h1F0000, 8'h9C, 1'b1);
      chk("R12 ignored status", status, 8'h02);
      chk("R12 ignored strobes", {cmd_accept, cmd_reject, dpd_active}, 1);
    end
    issue(8'hAB, 24'h0, 8'h0, 1'b1);
    chk("R12 release", dpd_active, 0);
    issue(8'h04, 24'h0, 8'h0, 1'b1);
    chk("R12 working again", status, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule